// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether an incoming Ethernet frame is meant for the local station. It watches the six destination address bytes as they arrive, one per clock, starting at a start strobe. From those bytes and a small set of static configuration inputs it produces an accept or reject verdict, together with a code that says which rule decided it. The verdict is held on the outputs until the next frame begins, so a downstream receive engine can sample it at its own pace.

The rules are tried in a fixed priority: a receive-off gate first, then promiscuous mode, then an exact compare against the station address, then the all-ones broadcast address, and last a 64-bit multicast hash table indexed by a CRC of the address. The CRC is built up byte by byte as the address streams in, so the verdict costs no cycles beyond the last byte.

Top module: `dest_addr_filter`

## Requirements
- R1: While reset (`rstN` low) is applied and after its release until the first completed address, `decValid` and `accept` are 0 and `reason` is 0 (idle).
- R2: If `rxEnable` is 0 when the sixth byte is presented, the frame is rejected with `reason` = 1, whatever the other settings and address are.
- R3: With `rxEnable` 1 and `promiscEn` 1, every frame is accepted with `reason` = 2, including frames that also match the station address.
- R4: The station address is given as three 16-bit words; word w carries address byte 2w in bits 15:8 and byte 2w+1 in bits 7:0 (byte 0 is the first byte received). A full six-byte match, with promiscuous mode off, accepts with `reason` = 3; any single byte differing is no station match.
- R5: A destination of six 0xFF bytes that is not a station match is accepted with `reason` = 4.
- R6: When none of R2 to R5 decides and `hashEn` is 1, the index is bits 31:26 of a reflected CRC-32 (polynomial 0xEDB88320 in shift-right form, register preset to 0xFFFFFFFF, each byte folded in least significant bit first, no final inversion) over the six bytes; table word `hashWords[index[5:4]]`, bit `index[3:0]` is looked up. A 1 accepts with `reason` = 5, a 0 rejects with `reason` = 6.
- R7: When none of R2 to R5 decides and `hashEn` is 0, the frame is rejected with `reason` = 7.
- R8: A byte is taken when `byteValid` is 1; it is byte 0 of a new address when `firstByte` is also 1. `decValid` is 0 from the clock edge that takes byte 0 until the edge that takes byte 5, and is 1 right after that edge. Configuration is used as it stands in the cycle byte 5 is presented.
- R9: Once `decValid` is 1, `accept` and `reason` keep their values until the next byte 0; bytes offered without `firstByte` in that period change nothing.
- R10: A byte 0 that arrives before an address is complete discards the partial address and starts a new one.
- R11: `accept` is 1 only while `decValid` is 1 and exactly when `reason` is 2, 3, 4 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | Address byte present on `byteData` this cycle |
| firstByte | input | 1 | The present byte is byte 0 of a new address |
| byteData | input | 8 | Destination address byte |
| rxEnable | input | 1 | Receive gate; 0 rejects every frame |
| promiscEn | input | 1 | Accept every frame |
| hashEn | input | 1 | Use the multicast hash table for unmatched frames |
| stationWords | input | 3x16 | Station address words, byte order as in R4 |
| hashWords | input | 4x16 | Hash table words, selection as in R6 |
| decValid | output | 1 | Verdict is present and held |
| accept | output | 1 | Frame accepted |
| reason | output | 3 | Deciding rule: 0 idle, 1 off, 2 promiscuous, 3 station, 4 broadcast, 5 hash hit, 6 hash miss, 7 no match |

## Verification
The bench sweeps several hundred multicast addresses against hash tables whose four words differ, so a design that picks the table word in the wrong direction, takes the wrong six CRC bits or inverts the CRC would accept and reject the wrong frames. It flips each station byte in turn and swaps the two bytes of a word, which catches a design that packs the station words in the other byte order or ignores a byte position. Priority cases pair promiscuous mode with a station match, a station address of all ones with broadcast, and receive-off with promiscuous broadcast, exposing a reordered rule chain. A restart in mid-address and stray bytes after a verdict catch a design that keeps stale CRC or compare state or lets the held verdict drift.

// File: rtl/daf_pkg.sv
`timescale 1ns/1ps
package daf_pkg;

  localparam int IDX_W = 4;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    RSN_IDLE     = 3'd0,
    RSN_OFF      = 3'd1,
    RSN_PROMISC  = 3'd2,
    RSN_STATION  = 3'd3,
    RSN_BCAST    = 3'd4,
    RSN_HASH     = 3'd5,
    RSN_HASHMISS = 3'd6,
    RSN_NOMATCH  = 3'd7
  } reason_e;

  typedef struct packed {
    logic             clearAcc;
    logic             takeByte;
    logic             lastByte;
    logic [IDX_W-1:0] byteIdx;
  } ctrl_strobes_t;

  // One byte of the shift-right CRC, least significant bit first.
  function automatic logic [31:0] crcStep(input logic [31:0] crcIn,
                                          input logic [7:0]  dataIn);
    logic [31:0] c;
    c = crcIn ^ {24'h0, dataIn};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/daf_ctrl.sv
`timescale 1ns/1ps
module daf_ctrl
  import daf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          byteValid,
  input  logic          firstByte,
  output ctrl_strobes_t strb,
  output logic          decValid
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);
  localparam logic             ONE_BYTE = (ADDR_BYTES == 1);

  logic [IDX_W-1:0] byteCnt;
  logic             collecting;

  always_comb begin
    strb = '0;
    if (byteValid && firstByte) begin
      strb.clearAcc = 1'b1;
      strb.takeByte = 1'b1;
      strb.byteIdx  = '0;
      strb.lastByte = ONE_BYTE;
    end else if (byteValid && collecting) begin
      strb.takeByte = 1'b1;
      strb.byteIdx  = byteCnt;
      strb.lastByte = (byteCnt == LAST_IDX);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt    <= '0;
      collecting <= 1'b0;
      decValid   <= 1'b0;
    end else if (strb.clearAcc) begin
      byteCnt    <= IDX_W'(1);
      collecting <= !ONE_BYTE;
      decValid   <= ONE_BYTE;
    end else if (strb.takeByte) begin
      byteCnt <= byteCnt + 1'b1;
      if (strb.lastByte) begin
        collecting <= 1'b0;
        decValid   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/daf_datapath.sv
`timescale 1ns/1ps
module daf_datapath
  import daf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int WORD_W     = 16,
  parameter int HASH_IDX_W = 6
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  ctrl_strobes_t                            strb,
  input  logic [7:0]                               byteData,
  input  logic                                     rxEnable,
  input  logic                                     promiscEn,
  input  logic                                     hashEn,
  input  logic [ADDR_BYTES*8/WORD_W-1:0][WORD_W-1:0] stationWords,
  input  logic [(1<<HASH_IDX_W)/WORD_W-1:0][WORD_W-1:0] hashWords,
  output logic                                     accept,
  output reason_e                                  reason
);

  localparam int BPW       = WORD_W / 8;
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int SEL_W     = HASH_IDX_W - BIT_W;
  localparam int EXP_SLOTS = 1 << IDX_W;

  // Expected station byte per position, unpacked from the word layout.
  logic [7:0] expByte [EXP_SLOTS];
  for (genvar g = 0; g < EXP_SLOTS; g++) begin : g_exp
    if (g < ADDR_BYTES) begin : g_live
      assign expByte[g] = stationWords[g / BPW][WORD_W-1-8*(g % BPW) -: 8];
    end else begin : g_pad
      assign expByte[g] = 8'h00;
    end
  end

  logic [31:0]           crcReg, crcBase, crcNext;
  logic                  staOk, staBase, staNext;
  logic                  bcOk, bcBase, bcNext;
  logic [HASH_IDX_W-1:0] hashIdx;
  logic                  hashHit;
  reason_e               rsnNext;

  always_comb begin
    crcBase = strb.clearAcc ? CRC_PRESET : crcReg;
    staBase = strb.clearAcc ? 1'b1 : staOk;
    bcBase  = strb.clearAcc ? 1'b1 : bcOk;
    crcNext = crcStep(crcBase, byteData);
    staNext = staBase && (byteData == expByte[strb.byteIdx]);
    bcNext  = bcBase && (byteData == 8'hFF);
  end

  assign hashIdx = crcNext[31 -: HASH_IDX_W];
  assign hashHit = hashWords[hashIdx[HASH_IDX_W-1 -: SEL_W]][hashIdx[BIT_W-1:0]];

  // Rule chain in priority order.
  always_comb begin
    if (!rxEnable)      rsnNext = RSN_OFF;
    else if (promiscEn) rsnNext = RSN_PROMISC;
    else if (staNext)   rsnNext = RSN_STATION;
    else if (bcNext)    rsnNext = RSN_BCAST;
    else if (hashEn)    rsnNext = hashHit ? RSN_HASH : RSN_HASHMISS;
    else                rsnNext = RSN_NOMATCH;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= CRC_PRESET;
      staOk  <= 1'b0;
      bcOk   <= 1'b0;
    end else if (strb.takeByte) begin
      crcReg <= crcNext;
      staOk  <= staNext;
      bcOk   <= bcNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reason <= RSN_IDLE;
      accept <= 1'b0;
    end else if (strb.lastByte) begin
      reason <= rsnNext;
      accept <= (rsnNext inside {RSN_PROMISC, RSN_STATION, RSN_BCAST, RSN_HASH});
    end else if (strb.clearAcc) begin
      reason <= RSN_IDLE;
      accept <= 1'b0;
    end
  end

endmodule

// File: rtl/dest_addr_filter.sv
`timescale 1ns/1ps
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int WORD_W     = 16,
  parameter int HASH_IDX_W = 6
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  logic                                          byteValid,
  input  logic                                          firstByte,
  input  logic [7:0]                                    byteData,
  input  logic                                          rxEnable,
  input  logic                                          promiscEn,
  input  logic                                          hashEn,
  input  logic [ADDR_BYTES*8/WORD_W-1:0][WORD_W-1:0]    stationWords,
  input  logic [(1<<HASH_IDX_W)/WORD_W-1:0][WORD_W-1:0] hashWords,
  output logic                                          decValid,
  output logic                                          accept,
  output logic [2:0]                                    reason
);

  ctrl_strobes_t strb;
  reason_e       rsnInt;

  daf_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .firstByte (firstByte),
    .strb      (strb),
    .decValid  (decValid)
  );

  daf_datapath #(
    .ADDR_BYTES (ADDR_BYTES),
    .WORD_W     (WORD_W),
    .HASH_IDX_W (HASH_IDX_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .byteData     (byteData),
    .rxEnable     (rxEnable),
    .promiscEn    (promiscEn),
    .hashEn       (hashEn),
    .stationWords (stationWords),
    .hashWords    (hashWords),
    .accept       (accept),
    .reason       (rsnInt)
  );

  assign reason = rsnInt;

endmodule

// File: rtl/daf_filter_chk.sv
`timescale 1ns/1ps
module daf_filter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       byteValid,
  input logic       firstByte,
  input logic       rxEnable,
  input logic       promiscEn,
  input logic       decValid,
  input logic       accept,
  input logic [2:0] reason
);

  // R8
  verdict_follows_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(decValid) |-> $past(byteValid));

  // R10
  start_clears_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && firstByte) |=> !decValid);

  // R11
  accept_only_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> decValid);

  // R9
  verdict_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !(byteValid && firstByte)) |=> (decValid && $stable(accept) && $stable(reason)));

  // R2
  gate_off_rejects_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(decValid) && !$past(rxEnable)) |-> (!accept && reason == 3'd1));

  // R3
  promisc_accepts_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(decValid) && $past(rxEnable && promiscEn)) |-> (accept && reason == 3'd2));

endmodule

bind dest_addr_filter daf_filter_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .byteValid (byteValid),
  .firstByte (firstByte),
  .rxEnable  (rxEnable),
  .promiscEn (promiscEn),
  .decValid  (decValid),
  .accept    (accept),
  .reason    (reason)
);

// File: tb/dest_addr_filter_bench.sv
`timescale 1ns/1ps
module dest_addr_filter_bench;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             byteValid = 1'b0;
  logic             firstByte = 1'b0;
  logic [7:0]       byteData = 8'h00;
  logic             rxEnable = 1'b0;
  logic             promiscEn = 1'b0;
  logic             hashEn = 1'b0;
  logic [2:0][15:0] stationWords = '0;
  logic [3:0][15:0] hashWords = '0;
  logic             decValid;
  logic             accept;
  logic [2:0]       reason;

  int total = 0;
  int bad   = 0;

  logic [47:0] staAddr;   // byte i at [8i +: 8]
  logic [63:0] hashVec;   // table bit n = hashVec[n]

  always #2.5 clk = ~clk;

  dest_addr_filter u_dest_addr_filter (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .firstByte(firstByte),
    .byteData(byteData), .rxEnable(rxEnable), .promiscEn(promiscEn),
    .hashEn(hashEn), .stationWords(stationWords), .hashWords(hashWords),
    .decValid(decValid), .accept(accept), .reason(reason)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  function automatic logic [31:0] crcOf(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      c = c ^ {24'h0, a[8*i +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [2:0] expReason(input logic [47:0] a);
    logic [5:0] idx;
    if (!rxEnable)            return 3'd1;
    if (promiscEn)            return 3'd2;
    if (a == staAddr)         return 3'd3;
    if (a == 48'hFFFF_FFFF_FFFF) return 3'd4;
    if (!hashEn)              return 3'd7;
    idx = crcOf(a)[31:26];
    return hashVec[idx] ? 3'd5 : 3'd6;
  endfunction

  task automatic loadConfig();
    @(negedge clk);
    for (int w = 0; w < 3; w++) stationWords[w] = {staAddr[16*w +: 8], staAddr[16*w+8 +: 8]};
    for (int w = 0; w < 4; w++) hashWords[w] = hashVec[16*w +: 16];
  endtask

  // R8: verdict low while bytes stream, high right after the sixth.
  task automatic sendFrame(input logic [47:0] a, input string tag);
    logic [2:0] er;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i > 0) check({"R8 busy ", tag}, decValid, 0);
      byteValid = 1'b1;
      firstByte = (i == 0);
      byteData  = a[8*i +: 8];
    end
    er = expReason(a);
    @(negedge clk);
    byteValid = 1'b0;
    firstByte = 1'b0;
    check({"R8 valid ", tag}, decValid, 1);
    check({"reason ", tag}, reason, er);
    check({"R11 accept ", tag}, accept, (er >= 3'd2 && er <= 3'd5));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    staAddr = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    hashVec = '0;
    loadConfig();
    repeat (3) @(negedge clk);
    check("R1 reset valid", decValid, 0);
    check("R1 reset accept", accept, 0);
    check("R1 reset reason", reason, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle valid", decValid, 0);
    check("R1 idle reason", reason, 0);

    // R2: gate off beats promiscuous and broadcast
    rxEnable = 0; promiscEn = 1; hashEn = 1; hashVec = '1; loadConfig();
    sendFrame(48'hFFFF_FFFF_FFFF, "R2 off bcast");
    sendFrame(staAddr, "R2 off station");

    // R3: promiscuous beats station match
    rxEnable = 1; promiscEn = 1; hashEn = 0;
    sendFrame(staAddr, "R3 promisc station");
    sendFrame(mk(8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60), "R3 promisc other");

    // R4 / R7: station compare and byte order
    promiscEn = 0; hashEn = 0;
    sendFrame(staAddr, "R4 exact");
    for (int b = 0; b < 6; b++) begin
      logic [47:0] a = staAddr;
      a[8*b +: 8] = a[8*b +: 8] ^ 8'h01;
      sendFrame(a, "R4 R7 one byte off");
    end
    for (int w = 0; w < 3; w++) begin
      logic [47:0] a = staAddr;
      a[16*w +: 8]   = staAddr[16*w+8 +: 8];
      a[16*w+8 +: 8] = staAddr[16*w +: 8];
      sendFrame(a, "R4 R7 word swap");
    end

    // R5: broadcast, and station of all ones wins over broadcast
    sendFrame(48'hFFFF_FFFF_FFFF, "R5 bcast");
    staAddr = 48'hFFFF_FFFF_FFFF; loadConfig();
    sendFrame(48'hFFFF_FFFF_FFFF, "R5 station ones");
    staAddr = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55); loadConfig();

    // R6: hash sweep over several tables
    hashEn = 1;
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: hashVec = 64'h0;
        1: hashVec = 64'hFFFF_FFFF_FFFF_FFFF;
        2: hashVec = 64'hA5A5_0F0F_3C3C_9999;
        default: hashVec = 64'h0123_4567_89AB_CDEF;
      endcase
      loadConfig();
      for (int k = 0; k < 256; k++) begin
        sendFrame(mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'(k * 7), 8'(k)), "R6 hash");
      end
    end
    hashEn = 0;
    sendFrame(mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01), "R7 hash off");

    // R9: stray bytes after a verdict change nothing
    sendFrame(48'hFFFF_FFFF_FFFF, "R9 base");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      byteValid = 1'b1; firstByte = 1'b0; byteData = 8'(8'h30 + i);
    end
    @(negedge clk);
    byteValid = 1'b0;
    @(negedge clk);
    check("R9 held valid", decValid, 1);
    check("R9 held reason", reason, 3'd4);
    check("R9 held accept", accept, 1);

    // R10: restart in mid-address
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      byteValid = 1'b1; firstByte = (i == 0); byteData = 8'hFF;
    end
    sendFrame(staAddr, "R10 restart station");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      byteValid = 1'b1; firstByte = (i == 0); byteData = staAddr[8*i +: 8];
    end
    sendFrame(48'hFFFF_FFFF_FFFF, "R10 restart bcast");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule